// File: doc/BRIEF.md
# Cascadable Fixed-Priority Interrupt Controller

This block gathers eight interrupt request lines, decides which one the processor should service next, and returns an interrupt vector when the processor acknowledges. Software reaches it through a byte-wide write port and a combinational read port. A single address bit selects between a command slot (address 0) and a data slot (address 1). A start word written to the command slot begins a fixed setup sequence on the data slot. That sequence sets the vector base, the cascade topology and the end-of-interrupt mode. After setup, data-slot writes load the mask, and command-slot writes issue end-of-interrupt and read-select commands.

Priority is fixed, with line 0 highest. A pending line reaches the processor only when it is unmasked and no line of equal or higher priority is in service. The `master_i` strap makes an instance a master or a slave. Two instances form a cascade in this way: the slave's interrupt output drives one master request line, the master's cascade address outputs drive the slave's cascade inputs, and both share the acknowledge strobe. When a slave line is acknowledged, the master marks its cascade line as in service and names the slave on the cascade bus. The slave then supplies the vector. Software must then clear both instances: first the slave's line, then the master's cascade line.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF and the request and in-service registers read 0x00. `int_o` stays low until the setup sequence completes, even for an unmasked pending line.
- R2: A command-slot write with bit 4 set starts setup. It clears the mask, request and in-service registers and selects the request register for command-slot reads. The next data-slot writes then load, in this order: the vector base; the cascade word (skipped when bit 1 of the start word is 1); and the mode word (present only when bit 0 of the start word is 1).
- R3: While `inta_i` is high, `vec_o` in the same cycle holds base bits 7:3 with the winning line number in bits 2:0, and `vec_en_o` is high. At the end of the acknowledge cycle, the winning request bit moves into the in-service register.
- R4: Among unmasked pending lines below the highest-priority in-service line, the lowest-numbered line wins. Lines at or below an in-service line are held off.
- R5: With bit 3 of the start word at 0, a rising edge latches a request that persists after the line falls. With bit 3 at 1, the request bit follows the line level.
- R6: Data-slot writes outside setup load the mask, which reads back at the data slot. A masked line still latches in the request register but does not raise `int_o`.
- R7: A command write of 0x60 plus n clears in-service bit n. A command write of 0x20 clears the lowest-numbered set in-service bit.
- R8: In a master, acknowledging a line whose bit is set in the cascade word drives that line number on `cas_o` with `cas_en_o` high. The master then supplies no vector and sets its own in-service bit for that line.
- R9: A slave answers an acknowledge only while `cas_en_i` is high and `cas_i` equals bits 2:0 of its cascade word. Clearing a slave's in-service bit leaves the master's in-service bits unchanged.
- R10: Bit 1 of the mode word enables automatic end of interrupt: an acknowledge then leaves the in-service register unchanged.
- R11: An acknowledge with no eligible request returns base plus 7 and changes no in-service bit.
- R12: A command write of 0x0A selects the request register and 0x0B selects the in-service register for command-slot reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master or standalone, 0 = slave |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 = command slot, 1 = data slot |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the slot on addr_i |
| irq_i | input | 8 | Interrupt request lines |
| int_o | output | 1 | Interrupt to the processor or the master |
| inta_i | input | 1 | Acknowledge strobe, one cycle |
| vec_o | output | 8 | Vector byte |
| vec_en_o | output | 1 | This instance drives the vector |
| cas_i | input | 3 | Cascade address from the master |
| cas_en_i | input | 1 | Cascade address valid |
| cas_o | output | 3 | Cascade address to slaves |
| cas_en_o | output | 1 | Cascade address valid |

## Verification
Each register write takes effect on the edge that ends its write cycle. A master line's rise appears on `int_o` one edge later. A slave line needs two edges: one to set the slave's request bit, and one for the master to latch the slave's output. The vector and cascade address are combinational during the acknowledge cycle. The in-service change shows after the edge that ends that cycle. The bench changes inputs on the falling edge, samples 1 ns later, and waits exactly those edge counts before each comparison.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_BASE,
    SEQ_CASC,
    SEQ_MODE,
    SEQ_RUN
  } seq_e;

  localparam int START_BIT   = 4;
  localparam int RDSEL_BIT   = 3;
  localparam int NEED4_BIT   = 0;
  localparam int SINGLE_BIT  = 1;
  localparam int LEVEL_BIT   = 3;
  localparam int AEOI_BIT    = 1;
  localparam logic [2:0] OP_EOI_NS = 3'b001;
  localparam logic [2:0] OP_EOI_SP = 3'b011;
endpackage

// File: rtl/pic8_cfg.sv
module pic8_cfg
  import pic8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LINE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              init_o,
  output logic              ready_o,
  output logic              level_o,
  output logic              single_o,
  output logic              aeoi_o,
  output logic [DATA_W-1:0] vbase_o,
  output logic [DATA_W-1:0] casw_o,
  output logic              imr_we_o,
  output logic              eoi_sp_o,
  output logic              eoi_ns_o,
  output logic [LINE_W-1:0] eoi_line_o,
  output logic              rd_isr_o
);
  seq_e seq_q;
  logic need4_q;
  logic wr_cmd, wr_dat, in_seq, is_op2, is_op3;
  logic [2:0] op;

  assign wr_cmd = wr_i & ~addr_i;
  assign wr_dat = wr_i & addr_i;
  assign in_seq = (seq_q == SEQ_BASE) || (seq_q == SEQ_CASC) || (seq_q == SEQ_MODE);
  assign init_o = wr_cmd & wdata_i[START_BIT];
  assign is_op2 = wr_cmd & ~wdata_i[START_BIT] & ~wdata_i[RDSEL_BIT];
  assign is_op3 = wr_cmd & ~wdata_i[START_BIT] & wdata_i[RDSEL_BIT];
  assign op     = wdata_i[DATA_W-1 -: 3];

  assign eoi_sp_o   = is_op2 && (op == OP_EOI_SP);
  assign eoi_ns_o   = is_op2 && (op == OP_EOI_NS);
  assign eoi_line_o = wdata_i[LINE_W-1:0];
  assign imr_we_o   = wr_dat & ~in_seq;
  assign ready_o    = (seq_q == SEQ_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q    <= SEQ_IDLE;
      need4_q  <= 1'b0;
      level_o  <= 1'b0;
      single_o <= 1'b0;
      aeoi_o   <= 1'b0;
      vbase_o  <= '0;
      casw_o   <= '0;
      rd_isr_o <= 1'b0;
    end else if (init_o) begin
      seq_q    <= SEQ_BASE;
      need4_q  <= wdata_i[NEED4_BIT];
      level_o  <= wdata_i[LEVEL_BIT];
      single_o <= wdata_i[SINGLE_BIT];
      aeoi_o   <= 1'b0;
      rd_isr_o <= 1'b0;
    end else begin
      if (is_op3 && wdata_i[1]) rd_isr_o <= wdata_i[0];
      if (wr_dat) begin
        unique case (seq_q)
          SEQ_BASE: begin
            vbase_o <= wdata_i;
            if (!single_o)    seq_q <= SEQ_CASC;
            else if (need4_q) seq_q <= SEQ_MODE;
            else              seq_q <= SEQ_RUN;
          end
          SEQ_CASC: begin
            casw_o <= wdata_i;
            seq_q  <= need4_q ? SEQ_MODE : SEQ_RUN;
          end
          SEQ_MODE: begin
            aeoi_o <= wdata_i[AEOI_BIT];
            seq_q  <= SEQ_RUN;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic8_regs.sv
module pic8_regs #(
  parameter int N_LINES = 8,
  parameter int LINE_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               level_i,
  input  logic               init_i,
  input  logic               imr_we_i,
  input  logic [N_LINES-1:0] imr_d_i,
  input  logic               take_i,
  input  logic [LINE_W-1:0]  take_line_i,
  input  logic               aeoi_i,
  input  logic               eoi_sp_i,
  input  logic               eoi_ns_i,
  input  logic [LINE_W-1:0]  eoi_line_i,
  output logic [N_LINES-1:0] irr_o,
  output logic [N_LINES-1:0] isr_o,
  output logic [N_LINES-1:0] imr_o
);
  localparam logic [N_LINES-1:0] ONE = {{(N_LINES-1){1'b0}}, 1'b1};

  logic [N_LINES-1:0] irq_q, rise, take_vec, clr_vec, irr_n, isr_n;

  assign rise     = irq_i & ~irq_q;
  assign take_vec = take_i ? (ONE << take_line_i) : '0;

  always_comb begin
    clr_vec = '0;
    if (eoi_sp_i) clr_vec = ONE << eoi_line_i;
    else if (eoi_ns_i) clr_vec = isr_o & (~isr_o + ONE);  // lowest set bit
  end

  assign irr_n = level_i ? (irq_i & ~take_vec) : ((irr_o & ~take_vec) | rise);
  assign isr_n = (isr_o & ~clr_vec) | (aeoi_i ? '0 : take_vec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '1;
      irr_o <= '0;
      isr_o <= '0;
      imr_o <= '1;
    end else if (init_i) begin
      irq_q <= '1;  // fresh edge required after setup starts
      irr_o <= '0;
      isr_o <= '0;
      imr_o <= '0;
    end else begin
      irq_q <= irq_i;
      irr_o <= irr_n;
      isr_o <= isr_n;
      if (imr_we_i) imr_o <= imr_d_i;
    end
  end
endmodule

// File: rtl/pic8_resolve.sv
module pic8_resolve #(
  parameter int N_LINES = 8,
  parameter int LINE_W  = 3,
  parameter int DATA_W  = 8
) (
  input  logic [N_LINES-1:0] irr_i,
  input  logic [N_LINES-1:0] isr_i,
  input  logic [N_LINES-1:0] imr_i,
  input  logic               ready_i,
  input  logic               master_i,
  input  logic               single_i,
  input  logic [DATA_W-1:0]  casw_i,
  input  logic [DATA_W-1:0]  vbase_i,
  input  logic               inta_i,
  input  logic [LINE_W-1:0]  cas_i,
  input  logic               cas_en_i,
  output logic               int_o,
  output logic               take_o,
  output logic [LINE_W-1:0]  take_line_o,
  output logic [DATA_W-1:0]  vec_o,
  output logic               vec_en_o,
  output logic [LINE_W-1:0]  cas_o,
  output logic               cas_en_o
);
  logic [LINE_W:0]    lim;
  logic [N_LINES-1:0] below, elig, casmap;
  logic [LINE_W-1:0]  win, slv_id;
  logic any, is_master, cas_hit, ack_m, ack_s;

  always_comb begin
    lim = (LINE_W+1)'(N_LINES);
    for (int k = N_LINES-1; k >= 0; k--)
      if (isr_i[k]) lim = (LINE_W+1)'(k);
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_below
    assign below[g] = ((LINE_W+1)'(g) < lim);
  end

  assign elig = irr_i & ~imr_i & below;
  assign any  = |elig;

  always_comb begin
    win = '0;
    for (int k = N_LINES-1; k >= 0; k--)
      if (elig[k]) win = LINE_W'(k);
  end

  assign casmap    = casw_i[N_LINES-1:0];
  assign slv_id    = casw_i[LINE_W-1:0];
  assign is_master = master_i | single_i;
  assign cas_hit   = ~single_i & any & casmap[win];
  assign ack_m     = is_master & inta_i & ready_i;
  assign ack_s     = ~is_master & inta_i & ready_i & cas_en_i & (cas_i == slv_id);

  assign int_o       = ready_i & any;
  assign take_o      = (ack_m | ack_s) & any;
  assign take_line_o = win;
  assign cas_en_o    = ack_m & cas_hit;
  assign cas_o       = cas_en_o ? win : '0;
  assign vec_en_o    = (ack_m & ~cas_hit) | ack_s;
  assign vec_o       = {vbase_i[DATA_W-1:LINE_W], (any ? win : {LINE_W{1'b1}})};
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl #(
  parameter int N_LINES = 8,
  parameter int DATA_W  = 8,
  localparam int LINE_W = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               master_i,
  input  logic               wr_i,
  input  logic               addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [N_LINES-1:0] irq_i,
  output logic               int_o,
  input  logic               inta_i,
  output logic [DATA_W-1:0]  vec_o,
  output logic               vec_en_o,
  input  logic [LINE_W-1:0]  cas_i,
  input  logic               cas_en_i,
  output logic [LINE_W-1:0]  cas_o,
  output logic               cas_en_o
);
  logic init, cfg_ready, level, single, aeoi, imr_we, eoi_sp, eoi_ns, rd_isr, take;
  logic [DATA_W-1:0]  vbase, casw;
  logic [LINE_W-1:0]  eoi_line, take_line;
  logic [N_LINES-1:0] irr, isr, imr;

  pic8_cfg #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_cfg (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .init_o(init), .ready_o(cfg_ready), .level_o(level), .single_o(single),
    .aeoi_o(aeoi), .vbase_o(vbase), .casw_o(casw), .imr_we_o(imr_we),
    .eoi_sp_o(eoi_sp), .eoi_ns_o(eoi_ns), .eoi_line_o(eoi_line), .rd_isr_o(rd_isr)
  );

  pic8_regs #(.N_LINES(N_LINES), .LINE_W(LINE_W)) u_regs (
    .clk_i, .rst_ni, .irq_i, .level_i(level), .init_i(init),
    .imr_we_i(imr_we), .imr_d_i(wdata_i[N_LINES-1:0]),
    .take_i(take), .take_line_i(take_line), .aeoi_i(aeoi),
    .eoi_sp_i(eoi_sp), .eoi_ns_i(eoi_ns), .eoi_line_i(eoi_line),
    .irr_o(irr), .isr_o(isr), .imr_o(imr)
  );

  pic8_resolve #(.N_LINES(N_LINES), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_res (
    .irr_i(irr), .isr_i(isr), .imr_i(imr), .ready_i(cfg_ready),
    .master_i, .single_i(single), .casw_i(casw), .vbase_i(vbase),
    .inta_i, .cas_i, .cas_en_i,
    .int_o, .take_o(take), .take_line_o(take_line),
    .vec_o, .vec_en_o, .cas_o, .cas_en_o
  );

  always_comb begin
    if (addr_i)      rdata_o = DATA_W'(imr);
    else if (rd_isr) rdata_o = DATA_W'(isr);
    else             rdata_o = DATA_W'(irr);
  end
endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk #(
  parameter int N_LINES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic               inta_i,
  input logic               int_o,
  input logic               vec_en_o,
  input logic               cas_en_o,
  input logic               cfg_ready,
  input logic               aeoi,
  input logic [N_LINES-1:0] irr,
  input logic [N_LINES-1:0] isr,
  input logic [N_LINES-1:0] imr
);
  a_r1_quiet_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ready |-> !int_o);

  a_r3_vec_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_en_o |-> inta_i);

  a_r4_int_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (|(irr & ~imr)));

  a_r8_cascade_marks_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_en_o && !wr_i && !aeoi) |=> (|isr));

  a_r10_aeoi_keeps_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && aeoi && !wr_i) |=> $stable(isr));

  a_r11_spurious_keeps_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o && !wr_i) |=> $stable(isr));
endmodule

bind pic8_ctrl pic8_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .inta_i(inta_i), .int_o(int_o),
  .vec_en_o(vec_en_o), .cas_en_o(cas_en_o), .cfg_ready(cfg_ready), .aeoi(aeoi),
  .irr(irr), .isr(isr), .imr(imr)
);

// File: tb/pic8_ctrl_test.sv
`timescale 1ns/1ps
module pic8_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_m = 0, wr_s = 0, addr = 0, inta = 0;
  logic [7:0] wdata = '0, irq_m = '0, irq_s = '0;
  logic [7:0] rd_m, rd_s, vec_m, vec_s;
  logic int_m, int_s, ven_m, ven_s, cen_m, cen_s;
  logic [2:0] cas_m, cas_s;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pic8_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(1'b1), .wr_i(wr_m), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_m), .irq_i({irq_m[7:3], int_s, irq_m[1:0]}),
    .int_o(int_m), .inta_i(inta), .vec_o(vec_m), .vec_en_o(ven_m),
    .cas_i(3'd0), .cas_en_i(1'b0), .cas_o(cas_m), .cas_en_o(cen_m)
  );

  pic8_ctrl u_slv (
    .clk_i(clk), .rst_ni(rst_n), .master_i(1'b0), .wr_i(wr_s), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_s), .irq_i(irq_s),
    .int_o(int_s), .inta_i(inta), .vec_o(vec_s), .vec_en_o(ven_s),
    .cas_i(cas_m), .cas_en_i(cen_m), .cas_o(cas_s), .cas_en_o(cen_s)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(bit slv, logic a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (slv) wr_s = 1; else wr_m = 1;
    @(negedge clk);
    wr_m = 0; wr_s = 0;
  endtask

  task automatic rd(bit slv, logic a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = slv ? rd_s : rd_m;
  endtask

  task automatic rd_isr(bit slv, output logic [7:0] v);
    wr(slv, 0, 8'h0B);
    rd(slv, 0, v);
  endtask

  task automatic rd_irr(bit slv, output logic [7:0] v);
    wr(slv, 0, 8'h0A);
    rd(slv, 0, v);
  endtask

  task automatic ack(output logic [7:0] v, output logic em, output logic es,
                     output logic [3:0] cas);
    @(negedge clk);
    inta = 1;
    #1;
    v = ven_m ? vec_m : vec_s;
    em = ven_m; es = ven_s; cas = {cen_m, cas_m};
    @(negedge clk);
    inta = 0;
  endtask

  task automatic sample_int(output logic v);
    @(negedge clk);
    #1 v = int_m;
  endtask

  task automatic setup(bit slv, logic [7:0] w1, logic [7:0] base, logic [7:0] cw,
                       logic [7:0] w4);
    wr(slv, 0, w1);
    wr(slv, 1, base);
    wr(slv, 1, cw);
    wr(slv, 1, w4);
  endtask

  task automatic t_reset;
    logic [7:0] v; logic i;
    #1 chk("R1 int after reset", {7'd0, int_m}, 8'h00);
    rd(0, 1, v); chk("R1 imr reset", v, 8'hFF);
    rd(0, 0, v); chk("R1 irr reset", v, 8'h00);
    wr(0, 1, 8'h00);
    @(negedge clk); irq_m[0] = 1;
    sample_int(i); chk("R1 int gated before setup", {7'd0, i}, 8'h00);
    @(negedge clk); irq_m[0] = 0;
  endtask

  task automatic t_init;
    logic [7:0] v;
    setup(0, 8'h11, 8'h20, 8'h04, 8'h01);
    setup(1, 8'h11, 8'h28, 8'h02, 8'h01);
    rd(0, 1, v); chk("R2 imr cleared", v, 8'h00);
    rd(0, 0, v); chk("R2 irr cleared", v, 8'h00);
    for (int k = 0; k < 8; k++) begin
      wr(0, 0, 8'h60 | 8'(k));
      wr(1, 0, 8'h60 | 8'(k));
    end
    rd_isr(0, v); chk("R7 R12 master isr after eoi sweep", v, 8'h00);
    rd_isr(1, v); chk("R7 slave isr after eoi sweep", v, 8'h00);
  endtask

  task automatic t_single;
    logic [7:0] v; logic em, es, i; logic [3:0] c;
    @(negedge clk); irq_m[5] = 1;
    sample_int(i); chk("R3 int on line 5", {7'd0, i}, 8'h01);
    @(negedge clk); irq_m[5] = 0;
    sample_int(i); chk("R5 edge latch holds", {7'd0, i}, 8'h01);
    ack(v, em, es, c);
    chk("R3 vector line 5", v, 8'h25);
    chk("R9 slave silent", {6'd0, em, es}, 8'h02);
    rd_isr(0, v); chk("R3 isr line 5", v, 8'h20);
    wr(0, 0, 8'h65);
    rd(0, 0, v); chk("R7 specific eoi 5", v, 8'h00);
  endtask

  task automatic t_prio;
    logic [7:0] v; logic em, es, i; logic [3:0] c;
    @(negedge clk); irq_m[6] = 1; irq_m[3] = 1;
    @(negedge clk);
    ack(v, em, es, c); chk("R4 lowest line wins", v, 8'h23);
    sample_int(i); chk("R4 lower line held off", {7'd0, i}, 8'h00);
    @(negedge clk); irq_m[1] = 1;
    sample_int(i); chk("R4 higher line preempts", {7'd0, i}, 8'h01);
    ack(v, em, es, c); chk("R4 vector line 1", v, 8'h21);
    rd_isr(0, v); chk("R4 nested isr", v, 8'h0A);
    wr(0, 0, 8'h20);
    rd(0, 0, v); chk("R7 nonspecific eoi", v, 8'h08);
    sample_int(i); chk("R4 still held by line 3", {7'd0, i}, 8'h00);
    wr(0, 0, 8'h63);
    sample_int(i); chk("R4 line 6 released", {7'd0, i}, 8'h01);
    ack(v, em, es, c); chk("R4 vector line 6", v, 8'h26);
    wr(0, 0, 8'h66);
    @(negedge clk); irq_m = '0;
  endtask

  task automatic t_mask;
    logic [7:0] v; logic em, es, i; logic [3:0] c;
    wr(0, 1, 8'h10);
    rd(0, 1, v); chk("R6 imr readback", v, 8'h10);
    @(negedge clk); irq_m[4] = 1;
    sample_int(i); chk("R6 masked line quiet", {7'd0, i}, 8'h00);
    rd_irr(0, v); chk("R6 R12 masked line latched", v, 8'h10);
    wr(0, 1, 8'h00);
    sample_int(i); chk("R6 unmask releases", {7'd0, i}, 8'h01);
    ack(v, em, es, c); chk("R6 vector line 4", v, 8'h24);
    wr(0, 0, 8'h64);
    @(negedge clk); irq_m[4] = 0;
  endtask

  task automatic t_spur;
    logic [7:0] v; logic em, es; logic [3:0] c;
    ack(v, em, es, c); chk("R11 spurious vector", v, 8'h27);
    rd_isr(0, v); chk("R11 isr untouched", v, 8'h00);
  endtask

  task automatic t_cascade;
    logic [7:0] v; logic em, es, i; logic [3:0] c;
    @(negedge clk); irq_s[3] = 1;
    @(negedge clk);
    sample_int(i); chk("R8 master sees slave", {7'd0, i}, 8'h01);
    ack(v, em, es, c);
    chk("R9 slave vector", v, 8'h2B);
    chk("R8 R9 vector owner", {6'd0, em, es}, 8'h01);
    chk("R8 cascade address", {4'd0, c}, 8'h0A);
    rd_isr(0, v); chk("R8 master cascade isr", v, 8'h04);
    rd_isr(1, v); chk("R9 slave isr", v, 8'h08);
    wr(1, 0, 8'h63);
    rd(1, 0, v); chk("R9 slave eoi", v, 8'h00);
    rd(0, 0, v); chk("R9 master unchanged", v, 8'h04);
    wr(0, 0, 8'h62);
    rd(0, 0, v); chk("R7 master cascade eoi", v, 8'h00);
    @(negedge clk); irq_s[3] = 0;
  endtask

  task automatic t_level;
    logic [7:0] v; logic em, es, i; logic [3:0] c;
    @(negedge clk); irq_m[0] = 1;
    @(negedge clk);
    ack(v, em, es, c);
    @(negedge clk); irq_m[0] = 0;
    wr(0, 1, 8'hF0);
    setup(0, 8'h19, 8'h20, 8'h04, 8'h01);
    rd(0, 1, v); chk("R2 re-setup clears imr", v, 8'h00);
    rd_isr(0, v); chk("R2 re-setup clears isr", v, 8'h00);
    @(negedge clk); irq_m[7] = 1;
    sample_int(i); chk("R5 level request", {7'd0, i}, 8'h01);
    @(negedge clk); irq_m[7] = 0;
    sample_int(i); chk("R5 level drops", {7'd0, i}, 8'h00);
  endtask

  task automatic t_aeoi;
    logic [7:0] v; logic em, es; logic [3:0] c;
    setup(0, 8'h11, 8'h20, 8'h04, 8'h03);
    @(negedge clk); irq_m[5] = 1;
    @(negedge clk);
    ack(v, em, es, c); chk("R10 vector", v, 8'h25);
    rd_isr(0, v); chk("R10 auto eoi isr", v, 8'h00);
    @(negedge clk); irq_m[5] = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_init;
    t_single;
    t_prio;
    t_mask;
    t_spur;
    t_cascade;
    t_level;
    t_aeoi;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=running exp=done");
    finish_run;
  end
endmodule